// File: doc/BRIEF.md
# Timer Compare Channel

This block is one output-compare channel that sits beside a free-running timer/counter. On every timer tick it checks the counter value against its active compare value. When the two are equal it gives a one-tick match pulse that the counter logic can use to restart, latches a sticky interrupt-request flag, and sets, clears or toggles a waveform pin. A 2-bit pin-action field picks which of these the pin does. The prescaler and the counter itself are outside the block. It receives the count, a tick enable, top and bottom indications and a strobe that fires whenever software writes the counter.

The compare value is written through a simple register write port. In the two direct modes (free-run and clear-on-match), a write lands in the active compare register at once. In the two pulse-width modes, a write lands in a shadow buffer. The active register copies the buffer only on a tick at the top of the count or at the bottom, depending on the mode, so the pulse width never changes partway through a period. A force strobe acts on the pin as though a match had occurred, but only in the direct modes. It sets no flag and gives no match pulse. After any software write to the counter, the next tick gives no match. This lets software load the counter with the compare value without causing an interrupt.

Top module: `tcmp_channel`

## Requirements
- R1: While reset is asserted and after it is released, `match_flag`, `cmp_pin`, `cmp_value` and the shadow buffer are all zero.
- R2: In a cycle where `tick` is 1, `count` equals `cmp_value` and no block is pending, `cmp_match` is 1 in that cycle and `match_flag` is 1 from the next cycle on.
- R3: In a cycle where `tick` is 0, `cmp_match` is 0 whatever the count.
- R4: `flag_clr` = 1 clears `match_flag` in the next cycle. If a match occurs in the same cycle, the flag stays 1.
- R5: The `pin_mode` field sets the pin action on a match or force event, with the pin updated in the next cycle: 01 toggles the pin, 10 drives it to 0 and 11 drives it to 1.
- R6: With `pin_mode` = 00, the pin holds its value through matches and forces.
- R7: The `wave_mode` field has four values: 00 is free-run, 01 is clear-on-match, 10 is pulse-width with the buffer loaded at top, and 11 is pulse-width with the buffer loaded at bottom. In modes 00 and 01, a `cmp_wr` write appears on `cmp_value` in the next cycle.
- R8: In modes 10 and 11, a `cmp_wr` write goes only to the shadow buffer. `cmp_value` takes the buffer's value only in the cycle after a tick that coincides with `at_top` (mode 10) or `at_bottom` (mode 11). In every other cycle it keeps its value.
- R9: In modes 00 and 01, `force_cmp` = 1 applies the pin action of R5 but leaves `match_flag` unchanged and `cmp_match` at 0.
- R10: In modes 10 and 11, `force_cmp` has no effect on the pin.
- R11: After a cycle with `cnt_wr` = 1, the first later cycle with `tick` = 1 gives no match. This holds even when many tick-free cycles come in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick enable |
| count | input | WIDTH | Current counter value |
| cnt_wr | input | 1 | Software wrote the counter this cycle |
| at_top | input | 1 | Counter is at the top of its sequence |
| at_bottom | input | 1 | Counter is at the bottom of its sequence |
| wave_mode | input | 2 | Waveform mode (R7) |
| pin_mode | input | 2 | Pin action on events (R5, R6) |
| cmp_wr | input | 1 | Write strobe for compare value |
| cmp_wdata | input | WIDTH | Compare write data |
| force_cmp | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | Write-one-to-clear of the flag |
| cmp_match | output | 1 | One-tick match pulse |
| match_flag | output | 1 | Sticky interrupt-request flag |
| cmp_pin | output | 1 | Waveform output pin |
| cmp_value | output | WIDTH | Active compare register |

## Verification
The bench drives a counter write followed by a long stall with no ticks, then a tick with the count equal to the compare value. A block that expires with time instead of on the next tick would raise the flag there. It writes the compare value in pulse-width mode away from the load point and checks that `cmp_value` does not move. A design with no buffer would change the pulse width partway through a period. It forces in both mode families and clears the flag in the same cycle as a match, which catches a force that sets the flag, a force that acts in pulse-width mode, and a clear that wins over a new match. A random phase, with counts drawn from a narrow range, is checked against a behavioural model on every cycle.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

   typedef enum logic [1:0] {
      WM_FREE    = 2'b00,
      WM_CLRMTCH = 2'b01,
      WM_PW_TOP  = 2'b10,
      WM_PW_BOT  = 2'b11
   } wave_e;

   typedef enum logic [1:0] {
      PM_OFF    = 2'b00,
      PM_TOGGLE = 2'b01,
      PM_LOW    = 2'b10,
      PM_HIGH   = 2'b11
   } pin_e;

   function automatic logic is_pulse_width(input logic [1:0] wm);
      return wm[1];
   endfunction

   function automatic logic pin_next(input logic [1:0] pm, input logic cur);
      case (pin_e'(pm))
         PM_TOGGLE: return ~cur;
         PM_LOW:    return 1'b0;
         PM_HIGH:   return 1'b1;
         default:   return cur;
      endcase
   endfunction

endpackage

// File: rtl/tcmp_cmpreg.sv
module tcmp_cmpreg
   import tcmp_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter bit BUFFERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       wave_mode,
   input  logic             tick,
   input  logic             at_top,
   input  logic             at_bottom,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] active
);

   logic pw;
   assign pw = is_pulse_width(wave_mode);

   generate
      if (BUFFERED) begin : g_buffered
         logic [WIDTH-1:0] shadow;
         logic             load_pt;

         assign load_pt = tick && ((wave_mode == WM_PW_TOP) ? at_top : at_bottom);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow <= '0;
            end else if (wr) begin
               shadow <= wdata;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               active <= '0;
            end else if (!pw && wr) begin
               active <= wdata;
            end else if (pw && load_pt) begin
               active <= shadow;
            end
         end

         // R8
         pw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pw && !load_pt) |=> $stable(active));

         // R7
         direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pw && wr) |=> (active == $past(wdata)));
      end else begin : g_direct
         logic unused_sync;
         assign unused_sync = ^{tick, at_top, at_bottom, pw};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               active <= '0;
            end else if (wr) begin
               active <= wdata;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tcmp_match.sv
module tcmp_match #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [WIDTH-1:0] count,
   input  logic [WIDTH-1:0] cmp,
   input  logic             cnt_wr,
   output logic             hit
);

   logic blk_pend;
   logic equal;

   assign equal = (count == cmp);
   assign hit   = tick && equal && !blk_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_pend <= 1'b0;
      end else if (cnt_wr) begin
         blk_pend <= 1'b1;
      end else if (tick) begin
         blk_pend <= 1'b0;
      end
   end

   // R11
   wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_wr) && tick) |-> !hit);

   // R3
   no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |-> !hit);

endmodule

// File: rtl/tcmp_pin.sv
module tcmp_pin
   import tcmp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  logic       force_cmp,
   input  logic [1:0] wave_mode,
   input  logic [1:0] pin_mode,
   input  logic       flag_clr,
   output logic       flag,
   output logic       pin
);

   logic force_ok;
   logic event_any;

   assign force_ok  = force_cmp && !is_pulse_width(wave_mode);
   assign event_any = hit || force_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (hit) begin
         flag <= 1'b1;
      end else if (flag_clr) begin
         flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin <= 1'b0;
      end else if (event_any) begin
         pin <= pin_next(pin_mode, pin);
      end
   end

   // R2
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);

   // R9
   force_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_cmp && !hit && !flag) |=> !flag);

   // R6
   pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode == PM_OFF) |=> $stable(pin));

   // R10
   pw_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pulse_width(wave_mode) && !hit) |=> $stable(pin));

endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
   import tcmp_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter bit BUFFERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [WIDTH-1:0] count,
   input  logic             cnt_wr,
   input  logic             at_top,
   input  logic             at_bottom,
   input  logic [1:0]       wave_mode,
   input  logic [1:0]       pin_mode,
   input  logic             cmp_wr,
   input  logic [WIDTH-1:0] cmp_wdata,
   input  logic             force_cmp,
   input  logic             flag_clr,
   output logic             cmp_match,
   output logic             match_flag,
   output logic             cmp_pin,
   output logic [WIDTH-1:0] cmp_value
);

   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         initial $fatal(1, "tcmp_channel: WIDTH must lie in 2..32");
      end
   endgenerate

   logic hit;

   tcmp_cmpreg #(.WIDTH(WIDTH), .BUFFERED(BUFFERED)) u_cmpreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wave_mode (wave_mode),
      .tick      (tick),
      .at_top    (at_top),
      .at_bottom (at_bottom),
      .wr        (cmp_wr),
      .wdata     (cmp_wdata),
      .active    (cmp_value)
   );

   tcmp_match #(.WIDTH(WIDTH)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .count  (count),
      .cmp    (cmp_value),
      .cnt_wr (cnt_wr),
      .hit    (hit)
   );

   tcmp_pin u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .force_cmp (force_cmp),
      .wave_mode (wave_mode),
      .pin_mode  (pin_mode),
      .flag_clr  (flag_clr),
      .flag      (match_flag),
      .pin       (cmp_pin)
   );

   assign cmp_match = hit;

   // R4
   clr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !hit) |=> !match_flag);

endmodule

// File: tb/tcmp_channel_tb.sv
module tcmp_channel_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic [W-1:0] count = '0;
   logic         cnt_wr = 1'b0;
   logic         at_top = 1'b0;
   logic         at_bottom = 1'b0;
   logic [1:0]   wave_mode = 2'b00;
   logic [1:0]   pin_mode = 2'b00;
   logic         cmp_wr = 1'b0;
   logic [W-1:0] cmp_wdata = '0;
   logic         force_cmp = 1'b0;
   logic         flag_clr = 1'b0;
   logic         cmp_match;
   logic         match_flag;
   logic         cmp_pin;
   logic [W-1:0] cmp_value;

   int checks = 0;
   int errors = 0;

   // behavioural reference state
   int m_cmp = 0;
   int m_buf = 0;
   int m_flag = 0;
   int m_pin = 0;
   int m_blk = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tcmp_channel #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .cnt_wr(cnt_wr),
      .at_top(at_top), .at_bottom(at_bottom), .wave_mode(wave_mode),
      .pin_mode(pin_mode), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
      .force_cmp(force_cmp), .flag_clr(flag_clr), .cmp_match(cmp_match),
      .match_flag(match_flag), .cmp_pin(cmp_pin), .cmp_value(cmp_value)
   );

   function automatic int exp_hit();
      return (tick && (int'(count) == m_cmp) && (m_blk == 0)) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      int h, ev, pwm, ldp;
      if (!rst_n) begin
         m_cmp = 0; m_buf = 0; m_flag = 0; m_pin = 0; m_blk = 0;
      end else begin
         h   = exp_hit();
         pwm = wave_mode >= 2 ? 1 : 0;
         ev  = h | ((force_cmp && !pwm) ? 1 : 0);
         ldp = tick && ((wave_mode == 2) ? at_top : at_bottom);
         if (h) m_flag = 1; else if (flag_clr) m_flag = 0;
         if (ev) begin
            if (pin_mode == 1) m_pin = 1 - m_pin;
            else if (pin_mode == 2) m_pin = 0;
            else if (pin_mode == 3) m_pin = 1;
         end
         if (!pwm && cmp_wr) m_cmp = int'(cmp_wdata);
         else if (pwm && ldp) m_cmp = m_buf;
         if (cmp_wr) m_buf = int'(cmp_wdata);
         if (cnt_wr) m_blk = 1; else if (tick) m_blk = 0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // compare every output against the model, away from the edge
   task automatic cmp_all();
      chk("R2 cmp_match", int'(cmp_match), exp_hit());
      chk("R4 match_flag", int'(match_flag), m_flag);
      chk("R5 cmp_pin", int'(cmp_pin), m_pin);
      chk("R8 cmp_value", int'(cmp_value), m_cmp);
   endtask

   task automatic idle_inputs();
      tick = 0; cnt_wr = 0; at_top = 0; at_bottom = 0;
      cmp_wr = 0; force_cmp = 0; flag_clr = 0;
   endtask

   // one cycle: inputs already set; compare after edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      cmp_all();
      idle_inputs();
   endtask

   initial begin
      int seen;
      idle_inputs();
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 flag", int'(match_flag), 0);
      chk("R1 pin", int'(cmp_pin), 0);
      chk("R1 value", int'(cmp_value), 0);
      rst_n = 1;
      step();
      chk("R1 value after release", int'(cmp_value), 0);

      // R7 direct write in free-run
      wave_mode = 2'b00; pin_mode = 2'b01;
      cmp_wr = 1; cmp_wdata = 8'd5; step();
      chk("R7 direct write", int'(cmp_value), 5);

      // R3 equal count without tick
      count = 8'd5; tick = 0;
      @(posedge clk); #1;
      chk("R3 no tick no match", int'(cmp_match), 0);
      @(negedge clk); cmp_all(); idle_inputs();

      // R2 match with tick, R5 toggle
      count = 8'd5; tick = 1;
      #1 chk("R2 match pulse", int'(cmp_match), 1);
      step();
      chk("R2 flag set", int'(match_flag), 1);
      chk("R5 toggle", int'(cmp_pin), 1);

      // R4 clear and match same cycle
      count = 8'd5; tick = 1; flag_clr = 1; step();
      chk("R4 match wins over clear", int'(match_flag), 1);
      flag_clr = 1; step();
      chk("R4 clear", int'(match_flag), 0);

      // R9 force in free-run: pin set, no flag
      pin_mode = 2'b11; force_cmp = 1;
      #1 chk("R9 force no pulse", int'(cmp_match), 0);
      step();
      chk("R9 force pin", int'(cmp_pin), 1);
      chk("R9 force no flag", int'(match_flag), 0);
      pin_mode = 2'b10; force_cmp = 1; step();
      chk("R5 clear action", int'(cmp_pin), 0);

      // R6 mode off holds pin
      pin_mode = 2'b00; count = 8'd5; tick = 1; step();
      chk("R6 hold on match", int'(cmp_pin), 0);
      force_cmp = 1; step();
      chk("R6 hold on force", int'(cmp_pin), 0);

      // R11 counter write then long stall
      flag_clr = 1; step();
      pin_mode = 2'b01; cnt_wr = 1; count = 8'd5; step();
      for (int i = 0; i < 20; i++) step();
      count = 8'd5; tick = 1;
      #1 chk("R11 blocked tick", int'(cmp_match), 0);
      step();
      chk("R11 no flag", int'(match_flag), 0);
      count = 8'd5; tick = 1; step();
      chk("R11 next tick matches", int'(match_flag), 1);

      // R8 buffered update at top
      wave_mode = 2'b10; cmp_wr = 1; cmp_wdata = 8'd9; step();
      chk("R8 not yet loaded", int'(cmp_value), 5);
      at_top = 1; tick = 0; step();
      chk("R8 no load without tick", int'(cmp_value), 5);
      at_bottom = 1; tick = 1; step();
      chk("R8 no load at bottom in top mode", int'(cmp_value), 5);
      at_top = 1; tick = 1; step();
      chk("R8 loaded at top", int'(cmp_value), 9);
      wave_mode = 2'b11; cmp_wr = 1; cmp_wdata = 8'd3; step();
      at_top = 1; tick = 1; step();
      chk("R8 no load at top in bottom mode", int'(cmp_value), 9);
      at_bottom = 1; tick = 1; step();
      chk("R8 loaded at bottom", int'(cmp_value), 3);

      // R10 force ignored in pulse-width mode
      seen = int'(cmp_pin);
      pin_mode = 2'b01; force_cmp = 1; step();
      chk("R10 force ignored", int'(cmp_pin), seen);

      // random phase compared each cycle
      for (int i = 0; i < 4000; i++) begin
         tick      = ($urandom_range(0, 2) != 0);
         count     = W'($urandom_range(0, 3));
         cnt_wr    = ($urandom_range(0, 9) == 0);
         at_top    = ($urandom_range(0, 3) == 0);
         at_bottom = ($urandom_range(0, 3) == 0);
         cmp_wr    = ($urandom_range(0, 5) == 0);
         cmp_wdata = W'($urandom_range(0, 3));
         force_cmp = ($urandom_range(0, 7) == 0);
         flag_clr  = ($urandom_range(0, 4) == 0);
         if ($urandom_range(0, 49) == 0) wave_mode = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 29) == 0) pin_mode = 2'($urandom_range(0, 3));
         step();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule